// File: doc/BRIEF.md
# Supply-Pulse Gap Command Decoder

This block turns a stream of digital strobes into programming commands for a small one-time configuration store. A level detector in front of it reports three kinds of supply excursion: a large excursion that opens a session, an excursion that closes it or asks for a store, and a small modulation pulse. The meaning of each small pulse lies in how long ago the previous one came. The block measures that interval in cycles of the 32768 Hz clock and uses it to step an instruction counter, shift a 0 into an 8-bit register, or shift a 1 into it.

The instruction counter selects one of six session states. State 1 measures the oscillator and state 2 measures the inhibition time. States 3, 4 and 5 write or check configuration words 0, 1 and 2. State 6 checks the identification word, which can only be read. When a store is accepted, the block raises a one-cycle write command together with the word index and the register contents. To read a word back, a single 1 is walked through the register, and the block reports where that 1 sits. Sessions close on a stop or store strobe. If no modulation pulse comes for two seconds, the session closes by itself.

Top module: `pulse_gap_decoder`

## Requirements
- R1: After reset the block is inactive, `instr_o` is 1, `shreg_o` is 0 and `write_o` is low.
- R2: A start strobe takes priority over every other strobe in the same cycle. From the next cycle `active_o` is 1, `instr_o` is 1 and `shreg_o` is 0, and no timing reference is held.
- R3: The first modulation pulse after a start changes neither `instr_o` nor `shreg_o`. It only sets the timing reference.
- R4: A pulse that comes 20 to 26 cycles after the reference raises `instr_o` by one. `instr_o` saturates at 6.
- R5: A gap of 53 to 58 cycles shifts in a 0 and a gap of 86 to 91 cycles shifts in a 1. The new bit enters at bit 7 and the older bits move one place toward bit 0, so after eight shifts the first bit sent sits in bit 0.
- R6: A pulse whose gap lies outside all three windows changes neither `instr_o` nor `shreg_o`, but it becomes the new timing reference.
- R7: When exactly one bit of `shreg_o` is set, `bitptr_valid_o` is 1 and `bitptr_o` gives that bit's index. In all other cases `bitptr_valid_o` is 0.
- R8: A stop strobe during a session makes the block inactive and does not raise `write_o`.
- R9: A store strobe in state 3, 4 or 5 raises `write_o` for exactly one cycle and makes the block inactive. `word_o` equals `instr_o` minus 3 in states 3 to 6 and is 0 otherwise, and `shreg_o` is held.
- R10: A store strobe in state 6, 1 or 2 ends the session without raising `write_o`.
- R11: If a session sees no modulation pulse for 65536 cycles after its last pulse (or after its start), it becomes inactive exactly on the 65536th cycle.
- R12: While the block is inactive, modulation, stop and store strobes have no effect on `instr_o`, `shreg_o` or `write_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session-open strobe |
| stop_i | input | 1 | Session-close strobe |
| store_i | input | 1 | Store-request strobe |
| pulse_i | input | 1 | Small modulation pulse strobe |
| active_o | output | 1 | A session is open |
| instr_o | output | 3 | Instruction state, 1 to 6 |
| word_o | output | 2 | Selected configuration word index |
| shreg_o | output | 8 | Shift register contents |
| bitptr_o | output | 3 | Index of the single set bit |
| bitptr_valid_o | output | 1 | Exactly one bit of the shift register is set |
| write_o | output | 1 | One-cycle write command |

## Verification
The gap classifier is driven with intervals at both ends of each acceptance window and one cycle outside each end. This shows that the window edges are inclusive and that a rejected gap still moves the reference. A full byte sent LSB first checks bit order, and a walking single one checks every pointer position and the empty register. Stores are issued in a writable state, in the identification state and in a measurement state to tell accepted writes from rejected ones. A silent session run to its limit checks the exact cycle on which it expires.

// File: rtl/pulse_gap_decoder.sv
module pulse_gap_decoder #(
  parameter int INC_MIN  = 20,
  parameter int INC_MAX  = 26,
  parameter int ZERO_MIN = 53,
  parameter int ZERO_MAX = 58,
  parameter int ONE_MIN  = 86,
  parameter int ONE_MAX  = 91,
  parameter int TIMEOUT  = 65536,
  parameter int NSTATES  = 6,
  parameter int DW       = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic                         store_i,
  input  logic                         pulse_i,
  output logic                         active_o,
  output logic [$clog2(NSTATES+1)-1:0] instr_o,
  output logic [1:0]                   word_o,
  output logic [DW-1:0]                shreg_o,
  output logic [$clog2(DW)-1:0]        bitptr_o,
  output logic                         bitptr_valid_o,
  output logic                         write_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int SW = $clog2(NSTATES + 1);
  localparam int PW = $clog2(DW);
  localparam int FIRST_WORD = 3;

  logic [CW-1:0] cnt;
  logic          ref_ok;
  logic [SW-1:0] word_full;

  wire is_inc  = (cnt >= CW'(INC_MIN))  && (cnt <= CW'(INC_MAX));
  wire is_zero = (cnt >= CW'(ZERO_MIN)) && (cnt <= CW'(ZERO_MAX));
  wire is_one  = (cnt >= CW'(ONE_MIN))  && (cnt <= CW'(ONE_MAX));
  wire can_wr  = (instr_o >= SW'(FIRST_WORD)) && (instr_o < SW'(NSTATES));

  assign word_full = instr_o - SW'(FIRST_WORD);
  assign word_o    = (instr_o >= SW'(FIRST_WORD)) ? word_full[1:0] : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      instr_o  <= SW'(1);
      shreg_o  <= '0;
      ref_ok   <= 1'b0;
      cnt      <= '0;
      write_o  <= 1'b0;
    end else begin
      write_o <= 1'b0;
      if (start_i) begin
        active_o <= 1'b1;
        instr_o  <= SW'(1);
        shreg_o  <= '0;
        ref_ok   <= 1'b0;
        cnt      <= CW'(1);
      end else if (active_o) begin
        if (stop_i || store_i) begin
          active_o <= 1'b0;
          write_o  <= store_i && can_wr;
        end else if (pulse_i) begin
          cnt    <= CW'(1);
          ref_ok <= 1'b1;
          if (ref_ok) begin
            if (is_inc) begin
              if (instr_o < SW'(NSTATES)) instr_o <= instr_o + SW'(1);
            end else if (is_zero) begin
              shreg_o <= {1'b0, shreg_o[DW-1:1]};
            end else if (is_one) begin
              shreg_o <= {1'b1, shreg_o[DW-1:1]};
            end
          end
        end else if (cnt == CW'(TIMEOUT)) begin
          active_o <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    bitptr_valid_o = $onehot(shreg_o);
    bitptr_o = '0;
    for (int i = 0; i < DW; i++)
      if (shreg_o[i]) bitptr_o = PW'(i);
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o && instr_o == SW'(1) && shreg_o == '0); // R2
  AST_INSTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> instr_o >= SW'(1) && instr_o <= SW'(NSTATES)); // R4
  AST_PTR_HITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bitptr_valid_o |-> shreg_o[bitptr_o]); // R7
  AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && stop_i && !start_i |=> !write_o && !active_o); // R8
  AST_WRITE_WORD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    write_o |-> instr_o >= SW'(FIRST_WORD) && instr_o < SW'(NSTATES) && !active_o); // R9
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    write_o |=> !write_o); // R9
  AST_ID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && store_i && !start_i && instr_o == SW'(NSTATES) |=> !write_o); // R10
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> cnt <= CW'(TIMEOUT)); // R11
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o && !start_i |=> $stable(shreg_o) && $stable(instr_o) && !write_o); // R12
endmodule

// File: tb/sim_pulse_gap_decoder.sv
module sim_pulse_gap_decoder;
  localparam int TMO = 65536;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, store_i = 0, pulse_i = 0;
  logic active_o, bitptr_valid_o, write_o;
  logic [2:0] instr_o, bitptr_o;
  logic [1:0] word_o;
  logic [7:0] shreg_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_gap_decoder u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .store_i(store_i), .pulse_i(pulse_i), .active_o(active_o), .instr_o(instr_o),
    .word_o(word_o), .shreg_o(shreg_o), .bitptr_o(bitptr_o),
    .bitptr_valid_o(bitptr_valid_o), .write_o(write_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic do_store();
    store_i = 1; @(negedge clk); store_i = 0;
  endtask
  task automatic gap_pulse(input int gap);
    repeat (gap - 1) @(negedge clk);
    pulse_i = 1; @(negedge clk); pulse_i = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) gap_pulse(b[i] ? 88 : 55);
  endtask

  task automatic t_reset();
    chk("R1", "active", active_o, 0);
    chk("R1", "instr", instr_o, 1);
    chk("R1", "shreg", shreg_o, 0);
    chk("R1", "write", write_o, 0);
  endtask

  task automatic t_increment();
    do_start();
    chk("R2", "active", active_o, 1);
    chk("R2", "instr", instr_o, 1);
    gap_pulse(22);
    chk("R3", "instr after reference", instr_o, 1);
    gap_pulse(20);
    chk("R4", "instr gap 20", instr_o, 2);
    for (int i = 0; i < 5; i++) gap_pulse(26);
    chk("R4", "instr saturated", instr_o, 6);
    chk("R9", "word in state 6", word_o, 3);
  endtask

  task automatic t_windows();
    do_start();
    gap_pulse(5);
    gap_pulse(19);
    chk("R6", "gap 19 ignored", instr_o, 1);
    gap_pulse(20);
    chk("R6", "reference moved by gap 19", instr_o, 2);
    gap_pulse(27);
    chk("R6", "gap 27 ignored", instr_o, 2);
    gap_pulse(86);
    chk("R5", "gap 86 shifts 1", shreg_o, 8'h80);
    gap_pulse(53);
    chk("R5", "gap 53 shifts 0", shreg_o, 8'h40);
    gap_pulse(58);
    chk("R5", "gap 58 shifts 0", shreg_o, 8'h20);
    gap_pulse(52);
    chk("R6", "gap 52 ignored", shreg_o, 8'h20);
    gap_pulse(59);
    chk("R6", "gap 59 ignored", shreg_o, 8'h20);
    gap_pulse(85);
    chk("R6", "gap 85 ignored", shreg_o, 8'h20);
    gap_pulse(91);
    chk("R5", "gap 91 shifts 1", shreg_o, 8'h90);
    gap_pulse(92);
    chk("R6", "gap 92 ignored", shreg_o, 8'h90);
    gap_pulse(200);
    gap_pulse(24);
    chk("R6", "reference moved by long gap", instr_o, 3);
  endtask

  task automatic t_byte_order();
    do_start();
    gap_pulse(3);
    send_byte(8'hB5);
    chk("R5", "LSB-first byte", shreg_o, 8'hB5);
    chk("R7", "many ones not valid", bitptr_valid_o, 0);
  endtask

  task automatic t_walk();
    do_start();
    chk("R7", "empty not valid", bitptr_valid_o, 0);
    gap_pulse(3);
    gap_pulse(87);
    chk("R7", "valid at 7", bitptr_valid_o, 1);
    chk("R7", "pointer 7", bitptr_o, 7);
    for (int k = 6; k >= 0; k--) begin
      gap_pulse(56);
      chk("R7", "walking pointer", bitptr_o, k);
    end
    chk("R7", "valid at 0", bitptr_valid_o, 1);
    gap_pulse(56);
    chk("R7", "walked out", bitptr_valid_o, 0);
  endtask

  task automatic t_store_ok();
    do_start();
    gap_pulse(3);
    for (int i = 0; i < 3; i++) gap_pulse(23);
    chk("R9", "word in state 4", word_o, 1);
    send_byte(8'h3C);
    do_store();
    chk("R9", "write raised", write_o, 1);
    chk("R9", "session closed", active_o, 0);
    chk("R9", "word held", word_o, 1);
    chk("R9", "data held", shreg_o, 8'h3C);
    @(negedge clk);
    chk("R9", "write one cycle", write_o, 0);
  endtask

  task automatic t_store_rejected();
    do_start();
    chk("R2", "shreg cleared on restart", shreg_o, 0);
    gap_pulse(3);
    for (int i = 0; i < 5; i++) gap_pulse(21);
    do_store();
    chk("R10", "no write in id state", write_o, 0);
    chk("R10", "session closed", active_o, 0);
    @(negedge clk);
    chk("R10", "still no write", write_o, 0);
    do_start();
    do_store();
    chk("R10", "no write in state 1", write_o, 0);
  endtask

  task automatic t_stop_idle();
    do_start();
    gap_pulse(3);
    gap_pulse(22); gap_pulse(22);
    gap_pulse(90);
    do_stop();
    chk("R8", "stop closes", active_o, 0);
    chk("R8", "stop no write", write_o, 0);
    gap_pulse(3);
    gap_pulse(22);
    chk("R12", "idle instr held", instr_o, 3);
    gap_pulse(56);
    chk("R12", "idle shreg held", shreg_o, 8'h80);
    do_store();
    chk("R12", "idle store no write", write_o, 0);
  endtask

  task automatic t_priority();
    store_i = 1; start_i = 1; @(negedge clk); store_i = 0; start_i = 0;
    chk("R2", "start wins", active_o, 1);
    chk("R2", "start wins no write", write_o, 0);
  endtask

  task automatic t_timeout();
    gap_pulse(4);
    repeat (TMO - 1) @(negedge clk);
    chk("R11", "alive one cycle before limit", active_o, 1);
    @(negedge clk);
    chk("R11", "expired at limit", active_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_increment();
    t_windows();
    t_byte_order();
    t_walk();
    t_store_ok();
    t_store_rejected();
    t_stop_idle();
    t_priority();
    t_timeout();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule